// File: doc/BRIEF.md
# Two-Byte Handshake Output Sequencer

This block moves a converter result onto an 8-bit external bus as two bytes, under the control of the receiver. A result is made of a magnitude, a polarity bit and an overrange bit. It is sent as two bytes, the upper byte first and the lower byte second. The receiver paces every byte with a single level input, `send_i`. While that level is high, the block pulses an active-low load strobe; the receiver's latches capture the byte on the strobe's rising edge. The receiver then pulls `send_i` low for as long as it needs to read the byte. The block keeps the byte and its enable steady until `send_i` goes high again, and then it moves on.

A transfer starts in one of two ways. A rising edge on `mode_i` sends the most recent result on demand. While `mode_i` stays high, every new result is sent as it arrives. The bytes of a transfer come from a private copy of the result, so a result that arrives mid-transfer does not disturb it. Such a result is held as pending. It is sent straight after the current transfer if `mode_i` is still high, and dropped otherwise.

Top module: `byte_handshake_seq`

## Requirements
- R1: The upper byte carries magnitude bits [11:8] in bits [3:0], polarity in bit 4, overrange in bit 5, and zero in bits [7:6]. The lower byte carries magnitude bits [7:0].
- R2: The upper byte is offered first, with `hi_en_no` low. The lower byte is offered next, with `lo_en_no` low. The two enables are never low together.
- R3: `res_vld_i` records the result whatever the level of `mode_i`. A rising edge of `mode_i` while idle starts a transfer of the most recent recorded result.
- R4: While `mode_i` is high, a `res_vld_i` pulse while idle starts a transfer of that result on the next clock.
- R5: When `send_i` is sampled high while a byte is offered, `load_no` is low for exactly one cycle, starting on the next cycle.
- R6: After the strobe, the byte and its enable are held for as long as `send_i` stays low. The sequence advances on the first clock that samples `send_i` high.
- R7: A result arriving during a transfer does not change the bytes in flight. It is sent next if `mode_i` is high when the lower byte is acknowledged, and dropped otherwise.
- R8: After the lower byte is acknowledged, both enables return high. `byte_o` is zero whenever no enable is low.
- R9: While `rst_ni` is low, the block is idle: all enables and the strobe are high, the bus is zero and nothing is pending.
- R10: A rising edge of `mode_i` during a transfer has no effect. A `res_vld_i` pulse while idle with `mode_i` low starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_mag_i | input | 12 | Result magnitude |
| res_neg_i | input | 1 | Result polarity |
| res_ovr_i | input | 1 | Result overrange |
| res_vld_i | input | 1 | Single-cycle pulse: new result present |
| mode_i | input | 1 | Transfer request level |
| send_i | input | 1 | Receiver ready / acknowledge level |
| byte_o | output | 8 | Byte data bus |
| hi_en_no | output | 1 | Upper byte enable, active low |
| lo_en_no | output | 1 | Lower byte enable, active low |
| load_no | output | 1 | Load strobe, active low |

## Verification
The bench builds the block with its default widths: a 12-bit magnitude and an 8-bit bus. With these widths the upper byte has four magnitude bits plus the flag bits and two spare zero bits, so every bit position of both bytes is checked. The receiver model's read latency can be set to zero, as for a transmitter that is always ready, or to several cycles, as for a parallel port that holds its ready line low until the byte has been read. This exercises both the back-to-back path and the hold path. Results that arrive during a transfer, changes on `mode_i` during a transfer, and a reset in the middle of a transfer are all reached with these settings.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI_OFFER,
    ST_HI_STRB,
    ST_HI_HOLD,
    ST_LO_OFFER,
    ST_LO_STRB,
    ST_LO_HOLD
  } hs_state_e;

  function automatic logic st_is_hi(hs_state_e s);
    return (s == ST_HI_OFFER) || (s == ST_HI_STRB) || (s == ST_HI_HOLD);
  endfunction

  function automatic logic st_is_lo(hs_state_e s);
    return (s == ST_LO_OFFER) || (s == ST_LO_STRB) || (s == ST_LO_HOLD);
  endfunction

  function automatic logic st_is_strb(hs_state_e s);
    return (s == ST_HI_STRB) || (s == ST_LO_STRB);
  endfunction
endpackage

// File: rtl/hs_result_store.sv
module hs_result_store #(
  parameter int MAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             neg_i,
  input  logic             ovr_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             busy_i,
  output logic [MAG_W-1:0] act_mag_o,
  output logic             act_neg_o,
  output logic             act_ovr_o,
  output logic             pend_o
);
  localparam int WORD_W = MAG_W + 2;

  logic [WORD_W-1:0] last_q, act_q, in_w;

  assign in_w = {ovr_i, neg_i, mag_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      act_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (vld_i) last_q <= in_w;
      // transfer copy loads only at start; newest result wins
      if (start_i) act_q <= vld_i ? in_w : last_q;
      if (start_i || done_i)    pend_o <= 1'b0;
      else if (vld_i && busy_i) pend_o <= 1'b1;
    end
  end

  assign {act_ovr_o, act_neg_o, act_mag_o} = act_q;

  assert_pend_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !vld_i) |=> !pend_o);
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mode_i,
  input  logic      send_i,
  input  logic      vld_i,
  input  logic      pend_i,
  output hs_state_e state_o,
  output logic      start_o,
  output logic      done_o,
  output logic      busy_o
);
  hs_state_e st_q, st_d;
  logic      mode_q, mode_rise;

  assign mode_rise = mode_i && !mode_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_LO_HOLD) && send_i;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    unique case (st_q)
      ST_IDLE:     if (mode_rise || (vld_i && mode_i)) start_o = 1'b1;
      ST_HI_OFFER: if (send_i) st_d = ST_HI_STRB;
      ST_HI_STRB:  st_d = ST_HI_HOLD;
      ST_HI_HOLD:  if (send_i) st_d = ST_LO_OFFER;
      ST_LO_OFFER: if (send_i) st_d = ST_LO_STRB;
      ST_LO_STRB:  st_d = ST_LO_HOLD;
      ST_LO_HOLD: begin
        if (send_i) begin
          if (mode_i && (pend_i || vld_i)) start_o = 1'b1;
          else                              st_d = ST_IDLE;
        end
      end
      default:     st_d = ST_IDLE;
    endcase
    if (start_o) st_d = ST_HI_OFFER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_i;
    end
  end

  assign state_o = st_q;

  assert_strobe_after_send_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_HI_OFFER || st_q == ST_LO_OFFER) && send_i) |=> st_is_strb(st_q));
  assert_hold_while_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_HI_HOLD) && !send_i) |=> (st_q == ST_HI_HOLD));
  assert_idle_no_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_IDLE) && !mode_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/hs_byte_drive.sv
module hs_byte_drive
  import hs_pkg::*;
#(
  parameter int MAG_W  = 12,
  parameter int BYTE_W = 8
) (
  input  hs_state_e         state_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic              neg_i,
  input  logic              ovr_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              hi_en_no,
  output logic              lo_en_no,
  output logic              load_no
);
  localparam int HI_W = MAG_W - BYTE_W;

  logic [BYTE_W-1:0] hi_byte, lo_byte;

  generate
    for (genvar b = 0; b < BYTE_W; b++) begin : g_hi
      if (b < HI_W) begin : g_mag
        assign hi_byte[b] = mag_i[BYTE_W + b];
      end else if (b == HI_W) begin : g_neg
        assign hi_byte[b] = neg_i;
      end else if (b == HI_W + 1) begin : g_ovr
        assign hi_byte[b] = ovr_i;
      end else begin : g_pad
        assign hi_byte[b] = 1'b0;
      end
    end
  endgenerate

  assign lo_byte  = mag_i[BYTE_W-1:0];
  assign hi_en_no = !st_is_hi(state_i);
  assign lo_en_no = !st_is_lo(state_i);
  assign load_no  = !st_is_strb(state_i);

  always_comb begin
    if (st_is_hi(state_i))      byte_o = hi_byte;
    else if (st_is_lo(state_i)) byte_o = lo_byte;
    else                        byte_o = '0;
  end
endmodule

// File: rtl/byte_handshake_seq.sv
module byte_handshake_seq
  import hs_pkg::*;
#(
  parameter int MAG_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAG_W-1:0]  res_mag_i,
  input  logic              res_neg_i,
  input  logic              res_ovr_i,
  input  logic              res_vld_i,
  input  logic              mode_i,
  input  logic              send_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              hi_en_no,
  output logic              lo_en_no,
  output logic              load_no
);
  hs_state_e        state;
  logic             start, done, busy, pend;
  logic [MAG_W-1:0] act_mag;
  logic             act_neg, act_ovr;

  hs_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .send_i (send_i),
    .vld_i  (res_vld_i),
    .pend_i (pend),
    .state_o(state),
    .start_o(start),
    .done_o (done),
    .busy_o (busy)
  );

  hs_result_store #(.MAG_W(MAG_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (res_vld_i),
    .mag_i    (res_mag_i),
    .neg_i    (res_neg_i),
    .ovr_i    (res_ovr_i),
    .start_i  (start),
    .done_i   (done),
    .busy_i   (busy),
    .act_mag_o(act_mag),
    .act_neg_o(act_neg),
    .act_ovr_o(act_ovr),
    .pend_o   (pend)
  );

  hs_byte_drive #(.MAG_W(MAG_W), .BYTE_W(BYTE_W)) u_drive (
    .state_i (state),
    .mag_i   (act_mag),
    .neg_i   (act_neg),
    .ovr_i   (act_ovr),
    .byte_o  (byte_o),
    .hi_en_no(hi_en_no),
    .lo_en_no(lo_en_no),
    .load_no (load_no)
  );

  assert_one_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!hi_en_no && !lo_en_no));
  assert_lo_after_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lo_en_no) |-> $past(!hi_en_no));
  assert_strobe_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_no |-> (!hi_en_no || !lo_en_no));
  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_no |=> load_no);
  assert_strobe_after_send_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_no) |-> $past(send_i));
  assert_hi_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_en_no && $past(!hi_en_no)) |-> (byte_o == $past(byte_o)));
  assert_lo_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_en_no && $past(!lo_en_no)) |-> (byte_o == $past(byte_o)));
  assert_bus_parked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_en_no && lo_en_no) |-> (byte_o == '0));
endmodule

// File: tb/byte_handshake_seq_bench.sv
`timescale 1ns/100ps
module byte_handshake_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mag = '0;
  logic        neg = 1'b0, ovr = 1'b0, vld = 1'b0, mode = 1'b0;
  logic        rx_off = 1'b0;
  logic        rx_ready = 1'b1;
  int          rx_lat = 0;
  int          rx_cnt = 0;
  logic        send_i;
  logic [7:0]  byte_o;
  logic        hi_en_no, lo_en_no, load_no;
  int          n_chk = 0, n_fail = 0;
  logic [7:0]  got[$];

  always #2.5 clk = ~clk;

  assign send_i = rx_ready && !rx_off;

  byte_handshake_seq u_byte_handshake_seq (
    .clk_i(clk), .rst_ni(rst_n), .res_mag_i(mag), .res_neg_i(neg), .res_ovr_i(ovr),
    .res_vld_i(vld), .mode_i(mode), .send_i(send_i), .byte_o(byte_o),
    .hi_en_no(hi_en_no), .lo_en_no(lo_en_no), .load_no(load_no)
  );

  function automatic logic [7:0] hi_of(logic [11:0] m, logic n, logic o);
    return {2'b00, o, n, m[11:8]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // receiver: records strobed bytes, drops ready for rx_lat cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      rx_ready <= 1'b1;
      rx_cnt   <= 0;
    end else if (!load_no) begin
      got.push_back(byte_o);
      if (rx_lat > 0) begin
        rx_ready <= 1'b0;
        rx_cnt   <= rx_lat;
      end
    end else if (rx_cnt > 0) begin
      rx_cnt <= rx_cnt - 1;
      if (rx_cnt == 1) rx_ready <= 1'b1;
    end
  end

  // behavioural reference model: phase 0 idle, 1..3 upper, 4..6 lower
  int          m_ph;
  logic [11:0] m_mag, l_mag;
  logic        m_neg, m_ovr, l_neg, l_ovr, m_pend, m_mprev;
  bit          go, fin, was_busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_mag = '0; l_mag = '0; m_neg = 0; m_ovr = 0;
      l_neg = 0; l_ovr = 0; m_pend = 0; m_mprev = 0;
    end else begin
      go = 0; fin = 0; was_busy = (m_ph != 0);
      case (m_ph)
        0: go = (mode && !m_mprev) || (vld && mode);
        1: if (send_i) m_ph = 2;
        2: m_ph = 3;
        3: if (send_i) m_ph = 4;
        4: if (send_i) m_ph = 5;
        5: m_ph = 6;
        6: if (send_i) begin
             fin = 1;
             if (mode && (m_pend || vld)) go = 1; else m_ph = 0;
           end
        default: m_ph = 0;
      endcase
      if (go) begin
        m_ph = 1;
        if (vld) begin m_mag = mag; m_neg = neg; m_ovr = ovr; end
        else     begin m_mag = l_mag; m_neg = l_neg; m_ovr = l_ovr; end
      end
      if (go || fin) m_pend = 0;
      else if (vld && was_busy) m_pend = 1;
      if (vld) begin l_mag = mag; l_neg = neg; l_ovr = ovr; end
      m_mprev = mode;
    end
  end

  // per-clock comparison, sampled 1 ns after the edge
  always @(posedge clk) begin
    logic e_hi, e_lo, e_ld;
    logic [7:0] e_b;
    #1;
    e_hi = !(m_ph >= 1 && m_ph <= 3);
    e_lo = !(m_ph >= 4 && m_ph <= 6);
    e_ld = !(m_ph == 2 || m_ph == 5);
    e_b  = !e_hi ? hi_of(m_mag, m_neg, m_ovr) : (!e_lo ? m_mag[7:0] : 8'h00);
    chk(hi_en_no === e_hi, "R2 hi_en_no", hi_en_no, e_hi);
    chk(lo_en_no === e_lo, "R2 lo_en_no", lo_en_no, e_lo);
    chk(load_no === e_ld, "R5 load_no", load_no, e_ld);
    chk(byte_o === e_b, "R1/R8 byte_o", byte_o, e_b);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic new_result(logic [11:0] m, logic n, logic o);
    @(negedge clk);
    mag = m; neg = n; ovr = o; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic expect_pair(logic [11:0] m, logic n, logic o, string tag);
    logic [7:0] b;
    chk(got.size() >= 2, {tag, " byte count"}, got.size(), 2);
    if (got.size() >= 2) begin
      b = got.pop_front();
      chk(b == hi_of(m, n, o), {tag, " upper byte"}, b, hi_of(m, n, o));
      b = got.pop_front();
      chk(b == m[7:0], {tag, " lower byte"}, b, m[7:0]);
    end
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    // R9: outputs during reset
    chk(hi_en_no && lo_en_no && load_no && byte_o == 0, "R9 reset idle",
        {hi_en_no, lo_en_no, load_no}, 3'b111);
    rst_n = 1'b1;
    tick(3);

    // R10 / R3: result with mode low is only recorded; mode rise sends it
    rx_lat = 3;
    new_result(12'hABC, 1'b1, 1'b0);
    tick(8);
    chk(hi_en_no && got.size() == 0, "R10 no transfer with mode low", hi_en_no, 1);
    mode = 1'b1;
    tick(30);
    expect_pair(12'hABC, 1'b1, 1'b0, "R3 on-demand");

    // R4: mode held high, each result sent, receiver always ready
    rx_lat = 0;
    new_result(12'h5A3, 1'b0, 1'b1);
    tick(12);
    expect_pair(12'h5A3, 1'b0, 1'b1, "R4 stream a");
    new_result(12'hF0F, 1'b1, 1'b1);
    tick(12);
    expect_pair(12'hF0F, 1'b1, 1'b1, "R4 stream b");

    // R7: mid-transfer result queued and sent next while mode high
    rx_lat = 6;
    new_result(12'h123, 1'b0, 1'b0);
    tick(2);
    new_result(12'h9E7, 1'b1, 1'b0);
    tick(60);
    expect_pair(12'h123, 1'b0, 1'b0, "R7 in flight");
    expect_pair(12'h9E7, 1'b1, 1'b0, "R7 pending sent");

    // R7: mid-transfer result dropped when mode falls
    new_result(12'h456, 1'b0, 1'b1);
    tick(2);
    new_result(12'h789, 1'b0, 1'b0);
    mode = 1'b0;
    tick(40);
    expect_pair(12'h456, 1'b0, 1'b1, "R7 drop case");
    chk(got.size() == 0 && hi_en_no && lo_en_no, "R7 pending dropped", got.size(), 0);

    // R10: mode rise during transfer ignored (latest is 789)
    mode = 1'b1;
    tick(3);
    mode = 1'b0;
    tick(1);
    mode = 1'b1;
    tick(40);
    expect_pair(12'h789, 1'b0, 1'b0, "R10 single transfer");
    chk(got.size() == 0, "R10 mode rise mid-transfer ignored", got.size(), 0);

    // R6: receiver not ready keeps upper byte offered without strobe
    rx_off = 1'b1;
    rx_lat = 0;
    new_result(12'hC3D, 1'b1, 1'b1);
    tick(10);
    chk(!hi_en_no && load_no && byte_o == hi_of(12'hC3D, 1'b1, 1'b1), "R6 offer held",
        byte_o, hi_of(12'hC3D, 1'b1, 1'b1));
    rx_off = 1'b0;
    tick(12);
    expect_pair(12'hC3D, 1'b1, 1'b1, "R6 released");
    // R8: idle after lower byte acknowledged
    chk(hi_en_no && lo_en_no && byte_o == 0, "R8 idle parked", byte_o, 0);

    // R9: reset in the middle of a transfer
    rx_lat = 8;
    new_result(12'h0FF, 1'b0, 1'b0);
    tick(3);
    mode = 1'b0;
    rst_n = 1'b0;
    #0.5;
    chk(hi_en_no && lo_en_no && load_no && byte_o == 0, "R9 reset mid-transfer",
        {hi_en_no, lo_en_no, load_no}, 3'b111);
    tick(2);
    rst_n = 1'b1;
    got.delete();
    tick(10);
    chk(hi_en_no && lo_en_no && got.size() == 0, "R9 nothing pending after reset",
        got.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule